// File: doc/BRIEF.md
# Integer Execution Unit with Early Register Forward

The block is an integer execution unit with three reservation-station slots in front of it. Dispatch writes one tagged operation per cycle into a free slot, together with both source operands. Each source arrives either with its value marked ready, or as a tag that still has to be woken up. A slot keeps watching two result buses. One is an external broadcast. The other is the unit's own forward port. A slot captures a matching value in the same cycle the value appears on either bus.

Any slot whose two operands are available may issue. When several slots are ready, the one dispatched earliest wins, whatever its slot index. The execute stage has three latency behaviours:
- single-cycle operations;
- a two-cycle arithmetic shift right that blocks the stage;
- a record-capable left shift. When its record flag is set, the left shift puts its register result on the forward port after its first cycle and its condition field on a separate port after its second cycle.

A dependent operation can therefore pick up the forwarded value while its producer is still busy.

Top module: `iu_split_unit`

## Requirements
- R1: After reset, `disp_full_o`, `fwd_valid_o`, `cr_valid_o` and `fin_valid_o` are all low.
- R2: Class 0 (`disp_opc_i`=0) computes a+b in one cycle. An operation dispatched in cycle k, with both sources ready and the unit idle, shows its result on the forward port with `fin_valid_o` high in cycle k+2, and neither is high in k+1 or k+3.
- R3: Class 1 computes the arithmetic shift right of a by b[4:0] over two execution cycles. The result and the finish appear in cycle k+3 and nothing appears in k+2. No other operation issues during its second cycle, so a ready successor dispatched in k+1 forwards in k+4.
- R4: Class 2 computes the logical shift left of a by b[4:0]. With the record flag clear it behaves like class 0: forward and finish in k+2, with no condition result.
- R5: Class 2 with the record flag set forwards the register result in k+2 with `fin_valid_o` low. It drives `cr_valid_o` and finishes in k+3 with `fwd_valid_o` low. The condition field `cr_o` is {bit2 = result negative, bit1 = result positive, bit0 = result zero}, with the result read as signed.
- R6: The record flag has no effect on classes 0 and 1: they finish on their own schedule and never drive `cr_valid_o`.
- R7: A slot with an unavailable source does not issue. A broadcast whose tag matches the source wakes the slot in the same cycle, so the slot issues at the next edge using the broadcast data.
- R8: A slot blocked on an operand does not stall a younger slot whose operands are ready.
- R9: Among ready slots, the earliest dispatched issues first, even when it sits at a higher slot index than a younger one.
- R10: `disp_full_o` is high while all three slots are occupied. A dispatch offered then is dropped and never executes.
- R11: A source whose tag matches the unit's own forward port captures the forwarded value in that cycle. A dependent of a single-cycle producer therefore forwards one cycle after the producer does. A dependent of a recorded class 2 producer forwards one cycle after the producer's condition result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dst_i | input | 4 | Destination tag of the dispatched operation |
| disp_opc_i | input | 2 | Operation class: 0 add, 1 shift right arithmetic, 2 shift left |
| disp_rec_i | input | 1 | Record flag (produce condition field) |
| disp_a_tag_i | input | 4 | Source A tag |
| disp_a_rdy_i | input | 1 | Source A value is already available |
| disp_a_val_i | input | 32 | Source A value |
| disp_b_tag_i | input | 4 | Source B tag |
| disp_b_rdy_i | input | 1 | Source B value is already available |
| disp_b_val_i | input | 32 | Source B value |
| disp_full_o | output | 1 | All slots occupied; dispatch refused |
| bc_valid_i | input | 1 | External result broadcast valid |
| bc_tag_i | input | 4 | Broadcast tag |
| bc_data_i | input | 32 | Broadcast data |
| fwd_valid_o | output | 1 | Register result valid |
| fwd_tag_o | output | 4 | Register result tag |
| fwd_data_o | output | 32 | Register result value |
| cr_valid_o | output | 1 | Condition result valid |
| cr_tag_o | output | 4 | Condition result tag |
| cr_o | output | 3 | Condition field {neg, pos, zero} |
| fin_valid_o | output | 1 | Operation finishes this cycle |
| fin_tag_o | output | 4 | Tag of the finishing operation |

## Verification
Each result is expected on a fixed timetable counted in negative clock edges from the edge where dispatch is driven. Single-cycle results and the early forward of a recorded shift are due at k+2. The arithmetic shift and the condition result of a recorded shift are due at k+3. Each extra stall or wait for a wakeup adds one cycle per blocking cycle. Every scenario task drives inputs and samples outputs only at falling edges. At each falling edge it checks the cycle where a result must appear and also the neighbouring cycles where it must not. As a result, an early or late result is reported as well as a wrong value.

// File: rtl/iu_pkg.sv
package iu_pkg;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 32;
  localparam int SH_W   = $clog2(DATA_W);
  localparam int CR_W   = 3;

  typedef enum logic [1:0] {
    OPC_ADD = 2'd0,
    OPC_SRA = 2'd1,
    OPC_SHL = 2'd2
  } opc_e;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              rdy;
    logic [DATA_W-1:0] val;
  } src_t;

  typedef struct packed {
    logic [TAG_W-1:0] dst;
    opc_e             opc;
    logic             rec;
    src_t             a;
    src_t             b;
  } uop_t;

  // capture from own forward bus first, then external broadcast
  function automatic src_t src_wake(input src_t s,
                                    input logic f_v, input logic [TAG_W-1:0] f_t,
                                    input logic [DATA_W-1:0] f_d,
                                    input logic b_v, input logic [TAG_W-1:0] b_t,
                                    input logic [DATA_W-1:0] b_d);
    src_t r;
    r = s;
    if (!s.rdy) begin
      if (f_v && f_t == s.tag) begin
        r.rdy = 1'b1;
        r.val = f_d;
      end else if (b_v && b_t == s.tag) begin
        r.rdy = 1'b1;
        r.val = b_d;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/iu_rs_entry.sv
module iu_rs_entry
  import iu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  uop_t              alloc_uop_i,
  input  logic              issue_i,
  input  logic              fwd_v_i,
  input  logic [TAG_W-1:0]  fwd_tag_i,
  input  logic [DATA_W-1:0] fwd_data_i,
  input  logic              bc_v_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              valid_o,
  output logic              ready_o,
  output logic [TAG_W-1:0]  dst_o,
  output opc_e              opc_o,
  output logic              rec_o,
  output logic [DATA_W-1:0] a_val_o,
  output logic [DATA_W-1:0] b_val_o
);
  logic valid_q;
  uop_t q, eff, new_eff;

  always_comb begin
    eff     = q;
    eff.a   = src_wake(q.a, fwd_v_i, fwd_tag_i, fwd_data_i, bc_v_i, bc_tag_i, bc_data_i);
    eff.b   = src_wake(q.b, fwd_v_i, fwd_tag_i, fwd_data_i, bc_v_i, bc_tag_i, bc_data_i);
    new_eff   = alloc_uop_i;
    new_eff.a = src_wake(alloc_uop_i.a, fwd_v_i, fwd_tag_i, fwd_data_i, bc_v_i, bc_tag_i, bc_data_i);
    new_eff.b = src_wake(alloc_uop_i.b, fwd_v_i, fwd_tag_i, fwd_data_i, bc_v_i, bc_tag_i, bc_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      q       <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      q       <= new_eff;
    end else begin
      if (issue_i) valid_q <= 1'b0;
      q <= eff;
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q & eff.a.rdy & eff.b.rdy;
  assign dst_o   = q.dst;
  assign opc_o   = q.opc;
  assign rec_o   = q.rec;
  assign a_val_o = eff.a.val;
  assign b_val_o = eff.b.val;
endmodule

// File: rtl/iu_age_pick.sv
module iu_age_pick #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] ready_i,
  output logic [N-1:0] grant_o
);
  // older_q[i][j]: slot i was written before slot j
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_i[i])                older_q[i][j] <= 1'b0;
          else if (alloc_i[j] && i != j) older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pick
    logic blk;
    always_comb begin
      blk = 1'b0;
      for (int j = 0; j < N; j++) blk = blk | (ready_i[j] & older_q[j][i]);
    end
    assign grant_o[i] = ready_i[i] & ~blk;
  end
endmodule

// File: rtl/iu_exec.sv
module iu_exec
  import iu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [TAG_W-1:0]  dst_i,
  input  opc_e              opc_i,
  input  logic              rec_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              can_issue_o,
  output logic              hold_o,
  output logic              fwd_v_o,
  output logic [TAG_W-1:0]  fwd_tag_o,
  output logic [DATA_W-1:0] fwd_data_o,
  output logic              cr_v_o,
  output logic [CR_W-1:0]   cr_o,
  output logic              fin_v_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic              ex_v_q, ex_sec_q, rec_q;
  opc_e              opc_q;
  logic [TAG_W-1:0]  dst_q;
  logic [DATA_W-1:0] a_q, b_q, res;
  logic              two, done;

  assign two  = (opc_q == OPC_SRA) | ((opc_q == OPC_SHL) & rec_q);
  assign done = ex_v_q & (~two | ex_sec_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_v_q   <= 1'b0;
      ex_sec_q <= 1'b0;
      opc_q    <= OPC_ADD;
      rec_q    <= 1'b0;
      dst_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
    end else if (issue_i) begin
      ex_v_q   <= 1'b1;
      ex_sec_q <= 1'b0;
      opc_q    <= opc_i;
      rec_q    <= rec_i;
      dst_q    <= dst_i;
      a_q      <= a_i;
      b_q      <= b_i;
    end else if (ex_v_q && two && !ex_sec_q) begin
      ex_sec_q <= 1'b1;
    end else if (done) begin
      ex_v_q   <= 1'b0;
      ex_sec_q <= 1'b0;
    end
  end

  always_comb begin
    case (opc_q)
      OPC_SRA: res = DATA_W'($signed(a_q) >>> b_q[SH_W-1:0]);
      OPC_SHL: res = a_q << b_q[SH_W-1:0];
      default: res = a_q + b_q;
    endcase
  end

  assign can_issue_o = ~ex_v_q | done;
  assign hold_o      = ex_v_q & two & ~ex_sec_q;
  assign fwd_v_o     = ex_v_q & ((opc_q == OPC_SRA) ? ex_sec_q : ~ex_sec_q);
  assign fwd_tag_o   = dst_q;
  assign fwd_data_o  = res;
  assign cr_v_o      = ex_v_q & ex_sec_q & (opc_q == OPC_SHL) & rec_q;
  assign cr_o        = {res[DATA_W-1], ~res[DATA_W-1] & (res != '0), res == '0};
  assign fin_v_o     = done;
  assign tag_o       = dst_q;
endmodule

// File: rtl/iu_split_unit.sv
module iu_split_unit
  import iu_pkg::*;
#(
  parameter int NUM_RS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [TAG_W-1:0]  disp_dst_i,
  input  logic [1:0]        disp_opc_i,
  input  logic              disp_rec_i,
  input  logic [TAG_W-1:0]  disp_a_tag_i,
  input  logic              disp_a_rdy_i,
  input  logic [DATA_W-1:0] disp_a_val_i,
  input  logic [TAG_W-1:0]  disp_b_tag_i,
  input  logic              disp_b_rdy_i,
  input  logic [DATA_W-1:0] disp_b_val_i,
  output logic              disp_full_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              fwd_valid_o,
  output logic [TAG_W-1:0]  fwd_tag_o,
  output logic [DATA_W-1:0] fwd_data_o,
  output logic              cr_valid_o,
  output logic [TAG_W-1:0]  cr_tag_o,
  output logic [CR_W-1:0]   cr_o,
  output logic              fin_valid_o,
  output logic [TAG_W-1:0]  fin_tag_o
);
  uop_t              disp_uop;
  logic [NUM_RS-1:0] rs_valid, rs_ready, alloc_vec, grant;
  logic [TAG_W-1:0]  ent_dst [NUM_RS];
  opc_e              ent_opc [NUM_RS];
  logic              ent_rec [NUM_RS];
  logic [DATA_W-1:0] ent_a   [NUM_RS];
  logic [DATA_W-1:0] ent_b   [NUM_RS];
  logic              can_issue, ex_hold, issue_any, found;
  logic [TAG_W-1:0]  sel_dst, ex_tag;
  opc_e              sel_opc;
  logic              sel_rec;
  logic [DATA_W-1:0] sel_a, sel_b;

  assign disp_uop = '{dst: disp_dst_i, opc: opc_e'(disp_opc_i), rec: disp_rec_i,
                      a: '{tag: disp_a_tag_i, rdy: disp_a_rdy_i, val: disp_a_val_i},
                      b: '{tag: disp_b_tag_i, rdy: disp_b_rdy_i, val: disp_b_val_i}};

  assign disp_full_o = &rs_valid;

  // lowest free slot takes the dispatch
  always_comb begin
    alloc_vec = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (!rs_valid[i] && !found) begin
        alloc_vec[i] = disp_valid_i;
        found        = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
    iu_rs_entry u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc_vec[i]),
      .alloc_uop_i(disp_uop),
      .issue_i    (grant[i]),
      .fwd_v_i    (fwd_valid_o),
      .fwd_tag_i  (fwd_tag_o),
      .fwd_data_i (fwd_data_o),
      .bc_v_i     (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_data_i  (bc_data_i),
      .valid_o    (rs_valid[i]),
      .ready_o    (rs_ready[i]),
      .dst_o      (ent_dst[i]),
      .opc_o      (ent_opc[i]),
      .rec_o      (ent_rec[i]),
      .a_val_o    (ent_a[i]),
      .b_val_o    (ent_b[i])
    );
  end

  iu_age_pick #(.N(NUM_RS)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .alloc_i(alloc_vec),
    .ready_i(rs_ready & {NUM_RS{can_issue}}),
    .grant_o(grant)
  );

  assign issue_any = |grant;

  always_comb begin
    sel_dst = '0;
    sel_opc = OPC_ADD;
    sel_rec = 1'b0;
    sel_a   = '0;
    sel_b   = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (grant[i]) begin
        sel_dst = ent_dst[i];
        sel_opc = ent_opc[i];
        sel_rec = ent_rec[i];
        sel_a   = ent_a[i];
        sel_b   = ent_b[i];
      end
    end
  end

  iu_exec u_exec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue_any),
    .dst_i      (sel_dst),
    .opc_i      (sel_opc),
    .rec_i      (sel_rec),
    .a_i        (sel_a),
    .b_i        (sel_b),
    .can_issue_o(can_issue),
    .hold_o     (ex_hold),
    .fwd_v_o    (fwd_valid_o),
    .fwd_tag_o  (fwd_tag_o),
    .fwd_data_o (fwd_data_o),
    .cr_v_o     (cr_valid_o),
    .cr_o       (cr_o),
    .fin_v_o    (fin_valid_o),
    .tag_o      (ex_tag)
  );

  assign cr_tag_o  = ex_tag;
  assign fin_tag_o = ex_tag;
endmodule

// File: rtl/iu_split_unit_chk.sv
module iu_split_unit_chk #(
  parameter int NUM_RS = 3,
  parameter int TAG_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              disp_valid_i,
  input logic              disp_full_o,
  input logic [NUM_RS-1:0] rs_valid,
  input logic [NUM_RS-1:0] grant,
  input logic              ex_hold,
  input logic              fwd_valid_o,
  input logic [TAG_W-1:0]  fwd_tag_o,
  input logic              cr_valid_o,
  input logic [TAG_W-1:0]  cr_tag_o,
  input logic              fin_valid_o,
  input logic [TAG_W-1:0]  fin_tag_o
);
  assert_fin_has_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_valid_o |-> (fwd_valid_o || cr_valid_o));

  assert_no_issue_in_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_hold |-> (grant == '0));

  assert_cr_after_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> ($past(fwd_valid_o) && $past(fwd_tag_o) == cr_tag_o));

  assert_cr_finishes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> (fin_valid_o && fin_tag_o == cr_tag_o && !fwd_valid_o));

  assert_grant_occupied_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant & ~rs_valid) == '0);

  assert_single_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  assert_full_refuse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_full_o && disp_valid_i) |=> ($countones(rs_valid) <= $past($countones(rs_valid))));
endmodule

bind iu_split_unit iu_split_unit_chk #(.NUM_RS(NUM_RS), .TAG_W(iu_pkg::TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .disp_valid_i(disp_valid_i),
  .disp_full_o (disp_full_o),
  .rs_valid    (rs_valid),
  .grant       (grant),
  .ex_hold     (ex_hold),
  .fwd_valid_o (fwd_valid_o),
  .fwd_tag_o   (fwd_tag_o),
  .cr_valid_o  (cr_valid_o),
  .cr_tag_o    (cr_tag_o),
  .fin_valid_o (fin_valid_o),
  .fin_tag_o   (fin_tag_o)
);

// File: tb/iu_split_unit_tb.sv
`timescale 1ns/1ps
module iu_split_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        disp_valid_i = 1'b0;
  logic [3:0]  disp_dst_i = '0;
  logic [1:0]  disp_opc_i = '0;
  logic        disp_rec_i = 1'b0;
  logic [3:0]  disp_a_tag_i = '0, disp_b_tag_i = '0;
  logic        disp_a_rdy_i = 1'b0, disp_b_rdy_i = 1'b0;
  logic [31:0] disp_a_val_i = '0, disp_b_val_i = '0;
  logic        disp_full_o;
  logic        bc_valid_i = 1'b0;
  logic [3:0]  bc_tag_i = '0;
  logic [31:0] bc_data_i = '0;
  logic        fwd_valid_o, cr_valid_o, fin_valid_o;
  logic [3:0]  fwd_tag_o, cr_tag_o, fin_tag_o;
  logic [31:0] fwd_data_o;
  logic [2:0]  cr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #10 clk_i = ~clk_i;

  iu_split_unit u_dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // drive at current negedge, hold one cycle
  task automatic disp(input logic [3:0] dst, input logic [1:0] opc, input logic rec,
                      input logic [3:0] at, input logic ar, input logic [31:0] av,
                      input logic [3:0] bt, input logic br, input logic [31:0] bv);
    disp_valid_i = 1'b1; disp_dst_i = dst; disp_opc_i = opc; disp_rec_i = rec;
    disp_a_tag_i = at; disp_a_rdy_i = ar; disp_a_val_i = av;
    disp_b_tag_i = bt; disp_b_rdy_i = br; disp_b_val_i = bv;
    tick();
    disp_valid_i = 1'b0;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [31:0] d);
    bc_valid_i = 1'b1; bc_tag_i = t; bc_data_i = d;
    tick();
    bc_valid_i = 1'b0;
  endtask

  task automatic exp_fwd(input string req, input logic [3:0] t, input logic [31:0] d);
    chk(req, "fwd_valid", 32'(fwd_valid_o), 32'd1);
    chk(req, "fwd_tag", 32'(fwd_tag_o), 32'(t));
    chk(req, "fwd_data", fwd_data_o, d);
  endtask

  task automatic t_reset();
    chk("R1", "full", 32'(disp_full_o), 0);
    chk("R1", "fwd_valid", 32'(fwd_valid_o), 0);
    chk("R1", "cr_valid", 32'(cr_valid_o), 0);
    chk("R1", "fin_valid", 32'(fin_valid_o), 0);
  endtask

  task automatic t_add();
    disp(4'd1, 2'd0, 1'b0, 4'd0, 1'b1, 32'd5, 4'd0, 1'b1, 32'd7);
    chk("R2", "fwd early", 32'(fwd_valid_o), 0);
    tick();
    exp_fwd("R2", 4'd1, 32'd12);
    chk("R2", "fin", 32'(fin_valid_o), 1);
    chk("R2", "cr", 32'(cr_valid_o), 0);
    tick();
    chk("R2", "fwd late", 32'(fwd_valid_o), 0);
    chk("R2", "fin late", 32'(fin_valid_o), 0);
  endtask

  task automatic t_sra();
    disp(4'd2, 2'd1, 1'b0, 4'd0, 1'b1, 32'hFFFF_FFF0, 4'd0, 1'b1, 32'd2);
    disp(4'd3, 2'd0, 1'b0, 4'd0, 1'b1, 32'd1, 4'd0, 1'b1, 32'd1);
    chk("R3", "fwd first cycle", 32'(fwd_valid_o), 0);
    chk("R3", "fin first cycle", 32'(fin_valid_o), 0);
    tick();
    exp_fwd("R3", 4'd2, 32'hFFFF_FFFC);
    chk("R3", "fin", 32'(fin_valid_o), 1);
    tick();
    exp_fwd("R3", 4'd3, 32'd2);
    tick();
  endtask

  task automatic t_shl();
    disp(4'd5, 2'd2, 1'b0, 4'd0, 1'b1, 32'd1, 4'd0, 1'b1, 32'd31);
    tick();
    exp_fwd("R4", 4'd5, 32'h8000_0000);
    chk("R4", "fin", 32'(fin_valid_o), 1);
    tick();
    chk("R4", "no cr", 32'(cr_valid_o), 0);
    chk("R4", "fwd late", 32'(fwd_valid_o), 0);
  endtask

  task automatic t_rec(input logic [3:0] t, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] res, input logic [2:0] crv);
    disp(t, 2'd2, 1'b1, 4'd0, 1'b1, a, 4'd0, 1'b1, b);
    tick();
    exp_fwd("R5", t, res);
    chk("R5", "fin early", 32'(fin_valid_o), 0);
    chk("R5", "cr early", 32'(cr_valid_o), 0);
    tick();
    chk("R5", "cr_valid", 32'(cr_valid_o), 1);
    chk("R5", "cr_tag", 32'(cr_tag_o), 32'(t));
    chk("R5", "cr", 32'(cr_o), 32'(crv));
    chk("R5", "fin", 32'(fin_valid_o), 1);
    chk("R5", "fin_tag", 32'(fin_tag_o), 32'(t));
    chk("R5", "fwd second", 32'(fwd_valid_o), 0);
  endtask

  task automatic t_rec_ignored();
    disp(4'd7, 2'd0, 1'b1, 4'd0, 1'b1, 32'd2, 4'd0, 1'b1, 32'd3);
    tick();
    exp_fwd("R6", 4'd7, 32'd5);
    chk("R6", "add fin", 32'(fin_valid_o), 1);
    tick();
    chk("R6", "add cr", 32'(cr_valid_o), 0);
    chk("R6", "add fin late", 32'(fin_valid_o), 0);
    disp(4'd8, 2'd1, 1'b1, 4'd0, 1'b1, 32'd8, 4'd0, 1'b1, 32'd1);
    tick();
    chk("R6", "sra early", 32'(fwd_valid_o), 0);
    tick();
    exp_fwd("R6", 4'd8, 32'd4);
    chk("R6", "sra cr", 32'(cr_valid_o), 0);
    tick();
    chk("R6", "sra cr late", 32'(cr_valid_o), 0);
  endtask

  task automatic t_bypass();
    disp(4'd9, 2'd0, 1'b0, 4'd12, 1'b0, 32'd0, 4'd0, 1'b1, 32'd10);
    disp(4'd10, 2'd0, 1'b0, 4'd0, 1'b1, 32'd1, 4'd0, 1'b1, 32'd2);
    chk("R7", "blocked no issue", 32'(fwd_valid_o), 0);
    tick();
    exp_fwd("R8", 4'd10, 32'd3);
    bcast(4'd12, 32'd100);
    exp_fwd("R7", 4'd9, 32'd110);
    tick();
  endtask

  task automatic t_full_age();
    disp(4'd1, 2'd0, 1'b0, 4'd13, 1'b0, 32'd0, 4'd0, 1'b1, 32'd1);
    disp(4'd2, 2'd0, 1'b0, 4'd14, 1'b0, 32'd0, 4'd0, 1'b1, 32'd1);
    disp(4'd3, 2'd0, 1'b0, 4'd15, 1'b0, 32'd0, 4'd0, 1'b1, 32'd1);
    chk("R10", "full", 32'(disp_full_o), 1);
    disp(4'd4, 2'd0, 1'b0, 4'd0, 1'b1, 32'd1, 4'd0, 1'b1, 32'd1);
    chk("R10", "still full", 32'(disp_full_o), 1);
    chk("R10", "dropped op absent", 32'(fwd_valid_o), 0);
    tick();
    chk("R10", "dropped op absent", 32'(fwd_valid_o), 0);
    bcast(4'd13, 32'd10);
    exp_fwd("R7", 4'd1, 32'd11);
    chk("R10", "slot freed", 32'(disp_full_o), 0);
    disp(4'd5, 2'd0, 1'b0, 4'd15, 1'b0, 32'd0, 4'd0, 1'b1, 32'd2);
    bcast(4'd15, 32'd20);
    exp_fwd("R9", 4'd3, 32'd21);
    tick();
    exp_fwd("R9", 4'd5, 32'd22);
    bcast(4'd14, 32'd0);
    exp_fwd("R9", 4'd2, 32'd1);
    tick();
    chk("R10", "dropped never runs", 32'(fwd_valid_o), 0);
  endtask

  task automatic t_fwd_dep();
    disp(4'd6, 2'd0, 1'b0, 4'd0, 1'b1, 32'd4, 4'd0, 1'b1, 32'd5);
    disp(4'd7, 2'd0, 1'b0, 4'd6, 1'b0, 32'd0, 4'd0, 1'b1, 32'd100);
    exp_fwd("R11", 4'd6, 32'd9);
    tick();
    exp_fwd("R11", 4'd7, 32'd109);
    tick();
    disp(4'd8, 2'd2, 1'b1, 4'd0, 1'b1, 32'd1, 4'd0, 1'b1, 32'd3);
    disp(4'd9, 2'd0, 1'b0, 4'd8, 1'b0, 32'd0, 4'd0, 1'b1, 32'd1);
    exp_fwd("R11", 4'd8, 32'd8);
    tick();
    chk("R11", "producer cr", 32'(cr_valid_o), 1);
    chk("R11", "dep waits", 32'(fwd_valid_o), 0);
    tick();
    exp_fwd("R11", 4'd9, 32'd9);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_add();
    t_sra();
    t_shl();
    t_rec(4'd4, 32'd3, 32'd4, 32'd48, 3'b010);
    t_rec(4'd6, 32'd0, 32'd5, 32'd0, 3'b001);
    t_rec(4'd11, 32'd1, 32'd31, 32'h8000_0000, 3'b100);
    t_rec_ignored();
    t_bypass();
    t_full_age();
    t_fwd_dep();
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule